// File: doc/BRIEF.md
# Rate-Selectable Serial Link Group

This block spreads a fixed budget of 16 bits per frame, in each direction, across a group of eight local serial link slots. A frame lasts eight cycles of a 320 MHz bit clock, and a one-cycle strobe marks each frame boundary. At each boundary the block captures a 16-bit downlink slice. It then serializes that slice across the links that the group's line rate leaves active:

- eight links at 80 Mb/s, with 2 bits each;
- four links at 160 Mb/s, with 4 bits each;
- two links at 320 Mb/s, with 8 bits each.

In the same frame it samples the uplink lines of the active links and packs them into a 16-bit slice. That slice is published with a one-cycle valid pulse.

Each link also gets a clock at a selectable frequency of 40, 80, 160 or 320 MHz. The clock is produced without generated clocks, as a pair of half-cycle levels per bit-clock cycle, intended for a double-data-rate output register. A link that is outside the current rate mode, or that is switched off by configuration, is powered down: its enable output is low, its data and clock outputs are held low and its uplink input is ignored.

A build-time option pins the group to 80 Mb/s, for the group that carries slow-control traffic. The rate, the per-link enables and the clock selections are captured only at frame boundaries.

Top module: `serial_link_group`

## Requirements
- R1: After reset, and in every cycle in which no frame is in progress, `tx_line`, `lclk_ddr` and `link_pwr_en` are all zero and `rx_valid` is low, apart from the publish pulse of R7.
- R2: With `rate_sel` = 2'b00 (80 Mb/s), links 0 to 7 are active. Link k sends slice bits [15-2k] and then [14-2k], each held for 4 cycles. The first bit appears in the cycle after the strobe edge.
- R3: With `rate_sel` = 2'b01 (160 Mb/s), links 0 to 3 are active. Link k sends bits [15-4k] down to [12-4k], most significant first, each held for 2 cycles.
- R4: With `rate_sel` = 2'b10 (320 Mb/s), links 0 and 1 are active. Link k sends bits [15-8k] down to [8-8k], most significant first, one per cycle.
- R5: A link outside the active set of the current rate has `link_pwr_en`, `tx_line` and `lclk_ddr` held low, and its `rx_line` has no effect on `rx_slice`.
- R6: A link inside the active set whose `link_en` bit was 0 at the frame strobe behaves as in R5, and its bit positions in `rx_slice` read 0.
- R7: For each active link, the uplink bit for each bit period is the `rx_line` value in the last cycle of that period. The slice uses the same bit mapping as the downlink. It is published with `rx_valid` high for exactly one cycle: the cycle after the frame's eighth cycle.
- R8: `rate_sel`, `link_en`, `clk_sel` and `tx_slice` are sampled only at the frame strobe. Changes to them in the middle of a frame do not alter that frame.
- R9: For an enabled link, the 2-bit field `clk_sel[2k+1:2k]` selects the clock pattern, written {first half, second half}. Code 3 (320 MHz) gives 2'b10 in every cycle. Code 2 (160 MHz) gives 2'b11 in even frame cycles and 2'b00 in odd ones. Code 1 (80 MHz) gives 2'b11 in frame cycles 0-1 and 4-5, and 2'b00 otherwise. Code 0 (40 MHz) gives 2'b11 in cycles 0-3 and 2'b00 in cycles 4-7.
- R10: With `FIXED_BASE_RATE` = 1, the group behaves as if `rate_sel` were always 2'b00, whatever its value.
- R11: `rate_sel` = 2'b11 is treated as 80 Mb/s.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 320 MHz bit clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_stb | input | 1 | One-cycle frame boundary strobe, every 8 cycles |
| rate_sel | input | 2 | Group line rate code |
| link_en | input | 8 | Per-link enable |
| clk_sel | input | 16 | Per-link clock frequency code, 2 bits per link |
| tx_slice | input | 16 | Downlink slice captured at the strobe |
| rx_line | input | 8 | Uplink serial inputs |
| tx_line | output | 8 | Downlink serial outputs |
| lclk_ddr | output | 16 | Per-link clock as {first half, second half} pairs |
| link_pwr_en | output | 8 | Driver and receiver enable per link |
| rx_slice | output | 16 | Gathered uplink slice |
| rx_valid | output | 1 | One-cycle pulse marking a new `rx_slice` |

## Verification
The embedded assertions watch, on every cycle, the following properties:

- powered-down links stay quiet;
- the latched rate never moves between strobes;
- the active-link count is always one of the three legal values;
- the publish pulse lasts a single cycle;
- a 160 MHz link clock toggles on every cycle within a frame;
- the pinned group never leaves the base rate.

Only the bench scenarios can show that each bit of the slice reaches the right link in the right cycle at every rate, and that the uplink is sampled in the last cycle of each bit period. The bench does this by driving the inverted bit on all other cycles. The scenarios also cover the exact clock patterns of each frequency code and the discarding of mid-frame configuration changes.

// File: rtl/slg_pkg.sv
`timescale 1ns/1ps
package slg_pkg;

    // Group line rate codes; the reserved code folds onto the base rate.
    typedef enum logic [1:0] {
        RATE_80   = 2'd0,
        RATE_160  = 2'd1,
        RATE_320  = 2'd2,
        RATE_RSVD = 2'd3
    } lane_rate_e;

    // Link clock frequency codes.
    typedef enum logic [1:0] {
        LCLK_40  = 2'd0,
        LCLK_80  = 2'd1,
        LCLK_160 = 2'd2,
        LCLK_320 = 2'd3
    } lclk_freq_e;

    // Largest rate shift: the base rate holds each bit for 2**MAX_SHIFT cycles.
    localparam int MAX_SHIFT = 2;

    function automatic lane_rate_e fold_rate(input logic [1:0] code);
        lane_rate_e r;
        r = lane_rate_e'(code);
        if (r == RATE_RSVD) r = RATE_80;
        return r;
    endfunction

    // log2 of the cycles each bit is held at the given rate.
    function automatic logic [1:0] rate_shift(input lane_rate_e r);
        logic [1:0] s;
        case (r)
            RATE_320: s = 2'd0;
            RATE_160: s = 2'd1;
            default:  s = 2'd2;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/slg_frame_ctrl.sv
`timescale 1ns/1ps
module slg_frame_ctrl
    import slg_pkg::*;
#(
    parameter int LINKS      = 8,
    parameter int PH_W       = 3,
    parameter bit FIXED_BASE = 1'b0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               frame_stb,
    input  logic [1:0]         rate_sel,
    input  logic [LINKS-1:0]   link_en,
    input  logic [2*LINKS-1:0] clk_sel,
    output logic               run,
    output logic [PH_W-1:0]    ph,
    output logic               last,
    output lane_rate_e         rate_q,
    output lane_rate_e         rate_nxt,
    output logic [LINKS-1:0]   link_on,
    output logic [2*LINKS-1:0] csel_q
);

    localparam logic [PH_W-1:0] PH_MAX = '1;

    logic [LINKS-1:0] en_q;
    logic [LINKS-1:0] mode_mask;

    always_comb begin
        rate_nxt = FIXED_BASE ? RATE_80 : fold_rate(rate_sel);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run    <= 1'b0;
            ph     <= '0;
            rate_q <= RATE_80;
            en_q   <= '0;
            csel_q <= '0;
        end else if (frame_stb) begin
            run    <= 1'b1;
            ph     <= '0;
            rate_q <= rate_nxt;
            en_q   <= link_en;
            csel_q <= clk_sel;
        end else if (run) begin
            if (ph == PH_MAX) begin
                run <= 1'b0;
                ph  <= '0;
            end else begin
                ph <= ph + 1'b1;
            end
        end
    end

    // Lower link slots stay active as the rate rises.
    always_comb begin
        for (int k = 0; k < LINKS; k++) begin
            mode_mask[k] = (k < (LINKS >> (MAX_SHIFT - int'(rate_shift(rate_q)))));
        end
        link_on = mode_mask & en_q & {LINKS{run}};
        last    = run && (ph == PH_MAX);
    end

    AST_RATE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !frame_stb |=> $stable(rate_q)); // R8

    AST_ACTIVE_COUNT: assert property (@(posedge clk) disable iff (rst)
        run |-> ($countones(mode_mask) == LINKS || $countones(mode_mask) == LINKS/2
                 || $countones(mode_mask) == LINKS/4)); // R5

    generate
        if (FIXED_BASE) begin : g_fixed_chk
            AST_FIXED_RATE: assert property (@(posedge clk) disable iff (rst)
                frame_stb |=> (rate_q == RATE_80)); // R10
        end
    endgenerate

endmodule

// File: rtl/slg_tx_serializer.sv
`timescale 1ns/1ps
module slg_tx_serializer
    import slg_pkg::*;
#(
    parameter int LINKS     = 8,
    parameter int SLICE_W   = 16,
    parameter int FRAME_CYC = 8,
    parameter int PH_W      = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [SLICE_W-1:0] tx_slice,
    input  lane_rate_e         rate_nxt,
    input  lane_rate_e         rate_q,
    input  logic [PH_W-1:0]    ph,
    input  logic [LINKS-1:0]   link_on,
    output logic [LINKS-1:0]   tx_line
);

    logic [FRAME_CYC-1:0] lane_q [LINKS];
    logic [PH_W-1:0]      bit_idx;

    // Bits of the slice owned by link k, left-aligned, first-sent at the top.
    function automatic logic [FRAME_CYC-1:0] lane_bits(
        input logic [SLICE_W-1:0] s, input lane_rate_e r, input int k);
        logic [FRAME_CYC-1:0] v;
        int sh, act, n;
        sh  = int'(rate_shift(r));
        act = LINKS >> (MAX_SHIFT - sh);
        n   = SLICE_W / act;
        v   = '0;
        for (int i = 0; i < FRAME_CYC; i++) begin
            if (k < act && i < n) v[FRAME_CYC-1-i] = s[SLICE_W-1-k*n-i];
        end
        return v;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < LINKS; k++) lane_q[k] <= '0;
        end else if (load) begin
            for (int k = 0; k < LINKS; k++) lane_q[k] <= lane_bits(tx_slice, rate_nxt, k);
        end
    end

    always_comb begin
        bit_idx = ph >> rate_shift(rate_q);
        for (int k = 0; k < LINKS; k++) begin
            tx_line[k] = link_on[k] & lane_q[k][FRAME_CYC-1-int'(bit_idx)];
        end
    end

endmodule

// File: rtl/slg_rx_gather.sv
`timescale 1ns/1ps
module slg_rx_gather
    import slg_pkg::*;
#(
    parameter int LINKS     = 8,
    parameter int SLICE_W   = 16,
    parameter int FRAME_CYC = 8,
    parameter int PH_W      = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               frame_stb,
    input  logic               run,
    input  logic               last,
    input  logic [PH_W-1:0]    ph,
    input  lane_rate_e         rate_q,
    input  logic [LINKS-1:0]   link_on,
    input  logic [LINKS-1:0]   rx_line,
    output logic [SLICE_W-1:0] rx_slice,
    output logic               rx_valid
);

    logic [FRAME_CYC-1:0] acc_q   [LINKS];
    logic [FRAME_CYC-1:0] acc_nxt [LINKS];
    logic [PH_W-1:0]      hold_mask;
    logic                 sample;
    logic [SLICE_W-1:0]   packed_slice;

    // Sample in the final cycle of every bit period.
    always_comb begin
        hold_mask = PH_W'((1 << rate_shift(rate_q)) - 1);
        sample    = run && ((ph & hold_mask) == hold_mask);
        for (int k = 0; k < LINKS; k++) begin
            acc_nxt[k] = sample ? {acc_q[k][FRAME_CYC-2:0], rx_line[k] & link_on[k]}
                                : acc_q[k];
        end
    end

    always_comb begin
        int sh, act, n;
        sh  = int'(rate_shift(rate_q));
        act = LINKS >> (MAX_SHIFT - sh);
        n   = SLICE_W / act;
        packed_slice = '0;
        for (int k = 0; k < LINKS; k++) begin
            for (int i = 0; i < FRAME_CYC; i++) begin
                if (k < act && i < n) packed_slice[SLICE_W-1-k*n-i] = acc_nxt[k][n-1-i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < LINKS; k++) acc_q[k] <= '0;
            rx_slice <= '0;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= last;
            if (last) rx_slice <= packed_slice;
            for (int k = 0; k < LINKS; k++) begin
                acc_q[k] <= (last || frame_stb) ? '0 : acc_nxt[k];
            end
        end
    end

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid); // R7

    AST_VALID_AFTER_FRAME: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_valid) |-> $past(run)); // R7

endmodule

// File: rtl/slg_lclk_gen.sv
`timescale 1ns/1ps
module slg_lclk_gen
    import slg_pkg::*;
#(
    parameter int LINKS = 8,
    parameter int PH_W  = 3
) (
    input  logic [PH_W-1:0]    ph,
    input  logic [LINKS-1:0]   link_on,
    input  logic [2*LINKS-1:0] csel_q,
    output logic [2*LINKS-1:0] lclk_ddr
);

    // Each pair is {first half, second half} of one bit-clock cycle.
    always_comb begin
        for (int k = 0; k < LINKS; k++) begin
            logic [1:0] pat;
            case (lclk_freq_e'(csel_q[2*k +: 2]))
                LCLK_320: pat = 2'b10;
                LCLK_160: pat = {2{~ph[0]}};
                LCLK_80:  pat = {2{~ph[1]}};
                default:  pat = {2{~ph[2]}};
            endcase
            lclk_ddr[2*k +: 2] = link_on[k] ? pat : 2'b00;
        end
    end

endmodule

// File: rtl/serial_link_group.sv
`timescale 1ns/1ps
module serial_link_group
    import slg_pkg::*;
#(
    parameter int LINKS           = 8,
    parameter int SLICE_W         = 16,
    parameter bit FIXED_BASE_RATE = 1'b0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               frame_stb,
    input  logic [1:0]         rate_sel,
    input  logic [LINKS-1:0]   link_en,
    input  logic [2*LINKS-1:0] clk_sel,
    input  logic [SLICE_W-1:0] tx_slice,
    input  logic [LINKS-1:0]   rx_line,
    output logic [LINKS-1:0]   tx_line,
    output logic [2*LINKS-1:0] lclk_ddr,
    output logic [LINKS-1:0]   link_pwr_en,
    output logic [SLICE_W-1:0] rx_slice,
    output logic               rx_valid
);

    // At the top rate only LINKS/4 links carry the whole slice.
    localparam int FRAME_CYC = SLICE_W / (LINKS >> MAX_SHIFT);
    localparam int PH_W      = $clog2(FRAME_CYC);
    localparam logic [PH_W-1:0] PH_MAX = '1;

    logic             run;
    logic             last;
    logic [PH_W-1:0]  ph;
    lane_rate_e       rate_q;
    lane_rate_e       rate_nxt;
    logic [LINKS-1:0] link_on;
    logic [2*LINKS-1:0] csel_q;

    slg_frame_ctrl #(
        .LINKS(LINKS), .PH_W(PH_W), .FIXED_BASE(FIXED_BASE_RATE)
    ) u_ctrl (
        .clk(clk), .rst(rst), .frame_stb(frame_stb), .rate_sel(rate_sel),
        .link_en(link_en), .clk_sel(clk_sel), .run(run), .ph(ph), .last(last),
        .rate_q(rate_q), .rate_nxt(rate_nxt), .link_on(link_on), .csel_q(csel_q)
    );

    slg_tx_serializer #(
        .LINKS(LINKS), .SLICE_W(SLICE_W), .FRAME_CYC(FRAME_CYC), .PH_W(PH_W)
    ) u_tx (
        .clk(clk), .rst(rst), .load(frame_stb), .tx_slice(tx_slice),
        .rate_nxt(rate_nxt), .rate_q(rate_q), .ph(ph), .link_on(link_on),
        .tx_line(tx_line)
    );

    slg_rx_gather #(
        .LINKS(LINKS), .SLICE_W(SLICE_W), .FRAME_CYC(FRAME_CYC), .PH_W(PH_W)
    ) u_rx (
        .clk(clk), .rst(rst), .frame_stb(frame_stb), .run(run), .last(last),
        .ph(ph), .rate_q(rate_q), .link_on(link_on), .rx_line(rx_line),
        .rx_slice(rx_slice), .rx_valid(rx_valid)
    );

    slg_lclk_gen #(
        .LINKS(LINKS), .PH_W(PH_W)
    ) u_clk (
        .ph(ph), .link_on(link_on), .csel_q(csel_q), .lclk_ddr(lclk_ddr)
    );

    assign link_pwr_en = link_on;

    generate
        for (genvar k = 0; k < LINKS; k++) begin : g_link_chk
            AST_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
                !link_on[k] |-> (!tx_line[k] && lclk_ddr[2*k +: 2] == 2'b00)); // R5

            AST_CLK160_TOGGLE: assert property (@(posedge clk) disable iff (rst)
                (link_on[k] && csel_q[2*k +: 2] == LCLK_160 && ph != PH_MAX && !frame_stb)
                |=> (lclk_ddr[2*k +: 2] != $past(lclk_ddr[2*k +: 2]))); // R9
        end
    endgenerate

endmodule

// File: tb/test_serial_link_group.sv
`timescale 1ns/1ps
module test_serial_link_group;

    localparam int CLK_PERIOD = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        frame_stb = 1'b0;
    logic [1:0]  rate_sel = 2'b00;
    logic [7:0]  link_en = 8'h00;
    logic [15:0] clk_sel = 16'h0000;
    logic [15:0] tx_slice = 16'h0000;
    logic [7:0]  rx_line = 8'h00;

    logic [7:0]  tx_line, tx_line_f;
    logic [15:0] lclk_ddr, lclk_ddr_f;
    logic [7:0]  link_pwr_en, link_pwr_en_f;
    logic [15:0] rx_slice, rx_slice_f;
    logic        rx_valid, rx_valid_f;

    int checks = 0;
    int fails = 0;
    bit prev_frame = 1'b0;
    bit done = 1'b0;
    logic [15:0] exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    serial_link_group i_serial_link_group (
        .clk(clk), .rst(rst), .frame_stb(frame_stb), .rate_sel(rate_sel),
        .link_en(link_en), .clk_sel(clk_sel), .tx_slice(tx_slice), .rx_line(rx_line),
        .tx_line(tx_line), .lclk_ddr(lclk_ddr), .link_pwr_en(link_pwr_en),
        .rx_slice(rx_slice), .rx_valid(rx_valid)
    );

    serial_link_group #(.FIXED_BASE_RATE(1'b1)) i_serial_link_group_fixed (
        .clk(clk), .rst(rst), .frame_stb(frame_stb), .rate_sel(rate_sel),
        .link_en(link_en), .clk_sel(clk_sel), .tx_slice(tx_slice), .rx_line(rx_line),
        .tx_line(tx_line_f), .lclk_ddr(lclk_ddr_f), .link_pwr_en(link_pwr_en_f),
        .rx_slice(rx_slice_f), .rx_valid(rx_valid_f)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic int shift_of(input logic [1:0] r);
        return (r == 2'd2) ? 0 : (r == 2'd1) ? 1 : 2;
    endfunction

    function automatic logic [1:0] lclk_exp(input bit on, input logic [1:0] code, input int c);
        if (!on) return 2'b00;
        case (code)
            2'd3:    return 2'b10;
            2'd2:    return (c % 2 == 0) ? 2'b11 : 2'b00;
            2'd1:    return ((c / 2) % 2 == 0) ? 2'b11 : 2'b00;
            default: return (c < 4) ? 2'b11 : 2'b00;
        endcase
    endfunction

    function automatic logic [7:0] tx_exp(input logic [15:0] tx, input logic [1:0] r,
                                          input logic [7:0] en, input int c);
        logic [7:0] v;
        int sh, n, act;
        sh = shift_of(r); n = 8 >> sh; act = 16 / n;
        v = 8'h00;
        for (int k = 0; k < 8; k++) begin
            if (k < act && en[k]) v[k] = tx[15 - k*n - (c >> sh)];
        end
        return v;
    endfunction

    function automatic logic [7:0] on_exp(input logic [1:0] r, input logic [7:0] en);
        logic [7:0] v;
        int act;
        act = 16 / (8 >> shift_of(r));
        for (int k = 0; k < 8; k++) v[k] = (k < act) && en[k];
        return v;
    endfunction

    // Driver: called at a falling edge; drives the strobe, then eight frame cycles.
    task automatic send_frame(input logic [15:0] tx, input logic [15:0] rxp,
                              input logic [1:0] rate, input logic [7:0] en,
                              input logic [15:0] csel, input bit glitch);
        int sh, n, act;
        string req;
        logic [15:0] exp_rx;
        logic [7:0]  on;
        logic [15:0] lexp;
        frame_stb = 1'b1; tx_slice = tx; rate_sel = rate; link_en = en; clk_sel = csel;
        sh = shift_of(rate); n = 8 >> sh; act = 16 / n;
        on = on_exp(rate, en);
        req = (rate == 2'd2) ? "R4" : (rate == 2'd1) ? "R3" : (rate == 2'd3) ? "R11" : "R2";
        exp_rx = 16'h0000;
        for (int k = 0; k < act; k++) begin
            if (en[k]) for (int i = 0; i < n; i++) exp_rx[15-k*n-i] = rxp[15-k*n-i];
        end
        for (int c = 0; c < 8; c++) begin
            @(posedge clk);
            @(negedge clk);
            frame_stb = 1'b0;
            if (glitch && c == 3) begin
                rate_sel = ~rate; link_en = ~en; clk_sel = ~csel; tx_slice = ~tx;
            end
            for (int k = 0; k < 8; k++) begin
                if (k < act) begin
                    logic b;
                    int m;
                    b = rxp[15 - k*n - (c >> sh)];
                    m = (1 << sh) - 1;
                    rx_line[k] = ((c & m) == m) ? b : ~b;   // R7 sample point
                end else begin
                    rx_line[k] = 1'b1;                        // R5 junk on idle slot
                end
            end
            if (c == 0) check("R7", "rx_valid at frame start", 32'(rx_valid), 32'(prev_frame));
            check(glitch ? "R8" : req, "tx_line", 32'(tx_line), 32'(tx_exp(tx, rate, en, c)));
            check("R5 R6", "link_pwr_en", 32'(link_pwr_en), 32'(on));
            for (int k = 0; k < 8; k++) lexp[2*k +: 2] = lclk_exp(on[k], csel[2*k +: 2], c);
            check("R9", "lclk_ddr", 32'(lclk_ddr), 32'(lexp));
            check("R10", "fixed tx_line", 32'(tx_line_f), 32'(tx_exp(tx, 2'd0, en, c)));
        end
        exp_q.push_back(exp_rx);
        prev_frame = 1'b1;
    endtask

    task automatic idle(input int cycles);
        frame_stb = 1'b0;
        for (int c = 0; c < cycles; c++) begin
            @(posedge clk);
            @(negedge clk);
            rx_line = 8'hFF;
            check("R1", "idle rx_valid", 32'(rx_valid), 32'(c == 0 && prev_frame));
            check("R1", "idle outputs", {8'h00, tx_line, link_pwr_en, 8'h00},
                  32'h0);
            check("R1", "idle lclk_ddr", 32'(lclk_ddr), 32'h0);
        end
        prev_frame = 1'b0;
    endtask

    // Monitor: compares each published uplink slice with the scoreboard.
    always @(negedge clk) begin
        if (!rst && rx_valid && !done) begin
            checks++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL R7 unexpected rx slice: actual=%h expected=none", rx_slice);
            end else begin
                logic [15:0] e;
                e = exp_q.pop_front();
                if (rx_slice !== e) begin
                    fails++;
                    $display("FAIL R7 rx_slice: actual=%h expected=%h", rx_slice, e);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 50000);
        fails++;
        $display("FAIL R1 watchdog: actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        check("R1", "reset tx_line", 32'(tx_line), 32'h0);
        check("R1", "reset lclk_ddr", 32'(lclk_ddr), 32'h0);
        check("R1", "reset pwr", 32'(link_pwr_en), 32'h0);
        check("R1", "reset rx_valid", 32'(rx_valid), 32'h0);
        idle(2);

        send_frame(16'hA5C3, 16'h3C96, 2'd0, 8'hFF, 16'hE4E4, 1'b0); // R2, all clock codes
        send_frame(16'h1234, 16'hF00D, 2'd1, 8'hFF, 16'h1B1B, 1'b0); // R3
        send_frame(16'hBEEF, 16'h5AA5, 2'd2, 8'hFF, 16'hAAAA, 1'b0); // R4
        send_frame(16'hFFFF, 16'hFFFF, 2'd0, 8'hA5, 16'hFFFF, 1'b0); // R6
        send_frame(16'h7E81, 16'hC3C3, 2'd1, 8'hF6, 16'h5555, 1'b0); // R5, R6
        send_frame(16'h6C39, 16'h9A6B, 2'd3, 8'hFF, 16'h0000, 1'b0); // R11
        send_frame(16'hC0DE, 16'h1EE7, 2'd2, 8'hFF, 16'hFFFF, 1'b1); // R8 mid-frame changes
        send_frame(16'h0F0F, 16'hB00B, 2'd0, 8'hFF, 16'h4E4E, 1'b0); // R8 new rate at boundary
        idle(10);

        check("R7", "scoreboard drained", 32'(exp_q.size()), 32'h0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule